// File: doc/BRIEF.md
# Smart Card Session Controller

This block is the card side of a contact smart card emulator. It follows the supply, clock and reset contacts driven by the reader and runs a session state machine from them. When reset is released on a powered and clocked contact set, it streams a stored Answer-To-Reset one byte at a time to a UART transmit handshake. The stored Answer-To-Reset can be replaced through a staging buffer and a commit strobe.

Once the Answer-To-Reset has gone out, the controller listens to the reader. A leading 0xFF byte opens a protocol parameter selection (PPS) request, and the controller walks it to its check byte. Any other byte begins a five-byte command header. After the fifth header byte, the controller turns the line around so that a procedure byte can be sent, and it presents the header to the host with a one-cycle valid strobe. Bit timing, the UART itself and the data phase that follows the procedure byte lie outside this block.

Top module: `card_session_ctrl`

## Requirements
- R1: After rst_n is released, `phase` is 0, `rx_en`, `tx_en`, `tx_valid` and `hdr_valid` are 0, and all three counters are 0. The phase codes are: 0 wait-power, 1 wait-clock, 2 wait-reset-release, 3 sending ATR, 4 in PPS, 5 wait-command, 6 in command.
- R2: When `vcc_on` is low at a clock edge, `phase` is 0 after that edge, whatever the previous phase was. This rule has priority over every other transition.
- R3: A rising `vcc_on` moves `phase` to 1. In phase 1, a high `clk_on` moves `phase` to 2 at the next edge.
- R4: A fall of `rst_act` from 1 to 0 while `vcc_on` and `clk_on` are both high moves `phase` to 3 from any phase. The same fall with `clk_on` low changes nothing.
- R5: In phase 3, `tx_valid` and `tx_en` are 1 and `tx_byte` is the stored ATR byte at the current position. The position advances only on a cycle where `tx_ready` is 1, and each new session starts at position 0.
- R6: After rst_n, the stored ATR is the four bytes 3B 02 14 50.
- R7: When the last ATR byte is accepted, `phase` becomes 5 with `rx_en`=1 and `tx_en`=0.
- R8: Writes through `atr_wr_*` fill a staging buffer, and indices of 33 or more are dropped. `atr_commit` copies the staging buffer to the stored ATR with length `atr_commit_len` only if that length is between 1 and 33 and `phase` is not 3. Any other commit leaves the stored ATR unchanged.
- R9: In phase 5, a received 0xFF moves `phase` to 4. The PPS request continues with a format byte whose bits 4, 5 and 6 each add one optional byte, and then a check byte. The check byte returns `phase` to 5.
- R10: In phase 5, any other received byte moves `phase` to 6 and is captured as the first header byte. The next four received bytes complete the header.
- R11: The edge that takes the fifth header byte sets `hdr_valid` for exactly one cycle. At that edge `hdr_bytes` holds the header, with the first byte in bits 7:0 and the fifth byte in bits 39:32. From then on `rx_en`=0 and `tx_en`=1, and further bytes are ignored.
- R12: Bytes received in phases 0 to 3 are ignored. They cause no phase change and no header output.
- R13: `rx_count` counts every `rx_valid` cycle, `tx_count` counts every accepted ATR byte, and `pps_count` counts every 0xFF that opens a PPS request. All three wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_on | input | 1 | Supply contact is powered |
| clk_on | input | 1 | Card clock contact is running |
| rst_act | input | 1 | Card reset contact is asserted |
| rx_valid | input | 1 | UART delivers a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_en | output | 1 | Receiver enable toward the UART |
| tx_ready | input | 1 | UART accepts the offered byte this cycle |
| tx_valid | output | 1 | A byte is offered for transmission |
| tx_byte | output | 8 | Offered byte |
| tx_en | output | 1 | Transmitter enable toward the UART |
| atr_wr_en | input | 1 | Write one staging byte |
| atr_wr_idx | input | 6 | Staging byte index |
| atr_wr_byte | input | 8 | Staging byte value |
| atr_commit | input | 1 | Request copy of the staging buffer into the stored ATR |
| atr_commit_len | input | 6 | Length of the ATR being committed |
| hdr_valid | output | 1 | One-cycle strobe: a full command header is present |
| hdr_bytes | output | 40 | Captured header, first byte in bits 7:0 |
| phase | output | 3 | Session phase code |
| rx_count | output | 32 | Received-byte counter |
| tx_count | output | 32 | Transmitted-byte counter |
| pps_count | output | 32 | PPS request counter |

## Verification
Each contact or byte input is sampled at one clock edge, and `phase`, `rx_en`, `tx_en` and the counters take their new values at that same edge. The bench therefore drives inputs one time unit after a rising edge and reads these results one time unit after the next rising edge. `hdr_valid` is registered from the fifth header byte, so it is high during the cycle that follows the edge taking that byte. A negative-edge monitor pops expected ATR bytes whenever `tx_valid` and `tx_ready` are both high before the accepting edge, and it pops expected headers while `hdr_valid` is high. A stalled `tx_ready` shows up as an unchanged `tx_byte` across several cycles.

// File: rtl/card_session_pkg.sv
package card_session_pkg;

  typedef enum logic [2:0] {
    PH_WAIT_PWR = 3'd0,
    PH_WAIT_CLK = 3'd1,
    PH_WAIT_RST = 3'd2,
    PH_SEND_ATR = 3'd3,
    PH_IN_PPS   = 3'd4,
    PH_WAIT_CMD = 3'd5,
    PH_IN_CMD   = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    PS_FMT  = 3'd0,
    PS_OPT1 = 3'd1,
    PS_OPT2 = 3'd2,
    PS_OPT3 = 3'd3,
    PS_CHK  = 3'd4
  } pps_step_e;

  localparam logic [7:0] PPS_INTRO    = 8'hFF;
  localparam int         HDR_N        = 5;
  localparam int         BOOT_ATR_LEN = 4;

  // Step that follows 'cur' in a PPS request; opt[k] flags optional byte k+1
  function automatic pps_step_e pps_after(pps_step_e cur, logic [2:0] opt);
    case (cur)
      PS_FMT:  return opt[0] ? PS_OPT1 : opt[1] ? PS_OPT2 : opt[2] ? PS_OPT3 : PS_CHK;
      PS_OPT1: return opt[1] ? PS_OPT2 : opt[2] ? PS_OPT3 : PS_CHK;
      PS_OPT2: return opt[2] ? PS_OPT3 : PS_CHK;
      default: return PS_CHK;
    endcase
  endfunction

  // A commit length is usable when it is non-empty and fits the store
  function automatic logic atr_len_ok(logic [7:0] len, logic [7:0] cap);
    return (len != 8'd0) && (len <= cap);
  endfunction

  // Contents of the stored ATR after reset
  function automatic logic [7:0] boot_atr_byte(int unsigned i);
    case (i)
      0:       return 8'h3B;
      1:       return 8'h02;
      2:       return 8'h14;
      3:       return 8'h50;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cs_atr_store.sv
module cs_atr_store
  import card_session_pkg::*;
#(
  parameter int ATR_MAX = 33,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic [IDX_W-1:0] commit_len,
  input  logic             busy,
  input  logic             rewind,
  input  logic             advance,
  output logic [7:0]       cur_byte,
  output logic             last
);

  logic [7:0]       stage_q [ATR_MAX];
  logic [7:0]       live_q  [ATR_MAX];
  logic [IDX_W-1:0] len_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic             accept;

  assign accept = commit && !busy && atr_len_ok(8'(commit_len), 8'(ATR_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ATR_MAX; i++) stage_q[i] <= 8'h00;
    end else if (wr_en && (wr_idx < IDX_W'(ATR_MAX))) begin
      stage_q[wr_idx] <= wr_byte;
    end
  end

  for (genvar g = 0; g < ATR_MAX; g++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rst_n)      live_q[g] <= boot_atr_byte(g);
      else if (accept) live_q[g] <= stage_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      len_q <= IDX_W'(BOOT_ATR_LEN);
    else if (accept) len_q <= commit_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_idx_q <= '0;
    else if (rewind)  rd_idx_q <= '0;
    else if (advance) rd_idx_q <= rd_idx_q + 1'b1;
  end

  assign cur_byte = live_q[rd_idx_q];
  assign last     = (rd_idx_q == len_q - 1'b1);

  // R8: a commit while the ATR is being sent leaves the length untouched
  p_busy_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && busy) |=> $stable(len_q));

  // R8: an out-of-range length is never taken over
  p_bad_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (commit_len == '0 || commit_len > IDX_W'(ATR_MAX))) |=> $stable(len_q));

endmodule

// File: rtl/cs_pps_track.sv
module cs_pps_track
  import card_session_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       take,
  input  logic [2:0] fmt_opt,
  output logic       done
);

  pps_step_e  step_q;
  logic [2:0] opt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= PS_FMT;
      opt_q  <= '0;
    end else if (start) begin
      step_q <= PS_FMT;
      opt_q  <= '0;
    end else if (take) begin
      if (step_q == PS_FMT) begin
        opt_q  <= fmt_opt;
        step_q <= pps_after(PS_FMT, fmt_opt);
      end else begin
        step_q <= pps_after(step_q, opt_q);
      end
    end
  end

  assign done = take && (step_q == PS_CHK);

  // R9: after the check byte the tracker waits at the check step until restarted
  p_chk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == PS_CHK && !start) |=> step_q == PS_CHK);

endmodule

// File: rtl/cs_hdr_capture.sv
module cs_hdr_capture #(
  parameter int HDR_BYTES = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   take,
  input  logic [7:0]             byte_in,
  output logic [8*HDR_BYTES-1:0] hdr_word,
  output logic                   hdr_pulse,
  output logic                   hdr_full
);

  localparam int CNT_W = $clog2(HDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hdr_word  <= '0;
      hdr_pulse <= 1'b0;
      hdr_full  <= 1'b0;
    end else begin
      hdr_pulse <= 1'b0;
      if (take && !hdr_full) begin
        hdr_word[int'(cnt_q)*8 +: 8] <= byte_in;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(HDR_BYTES - 1)) begin
          hdr_pulse <= 1'b1;
          hdr_full  <= 1'b1;
        end
      end else if (clr) begin
        cnt_q    <= '0;
        hdr_full <= 1'b0;
      end
    end
  end

  // R11: the header strobe never lasts two cycles
  p_hdr_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pulse |=> !hdr_pulse);

  // R11: once the header is complete no further byte is stored
  p_hdr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_full && !clr) |=> $stable(hdr_word));

endmodule

// File: rtl/card_session_ctrl.sv
module card_session_ctrl
  import card_session_pkg::*;
#(
  parameter int ATR_MAX = 33,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vcc_on,
  input  logic                 clk_on,
  input  logic                 rst_act,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  output logic                 rx_en,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic [7:0]           tx_byte,
  output logic                 tx_en,
  input  logic                 atr_wr_en,
  input  logic [IDX_W-1:0]     atr_wr_idx,
  input  logic [7:0]           atr_wr_byte,
  input  logic                 atr_commit,
  input  logic [IDX_W-1:0]     atr_commit_len,
  output logic                 hdr_valid,
  output logic [8*HDR_N-1:0]   hdr_bytes,
  output logic [2:0]           phase,
  output logic [CNT_W-1:0]     rx_count,
  output logic [CNT_W-1:0]     tx_count,
  output logic [CNT_W-1:0]     pps_count
);

  phase_e state_q, state_d;
  logic   vcc_q, rst_q;

  // named internal events
  logic pwr_rise, rel_evt, start_atr, tx_fire, rx_hit;
  logic pps_start, pps_take, pps_done, hdr_take, hdr_full;
  logic atr_last;

  assign pwr_rise  = vcc_on && !vcc_q;
  assign rel_evt   = rst_q && !rst_act;
  assign start_atr = rel_evt && vcc_on && clk_on;
  assign tx_fire   = tx_valid && tx_ready;
  assign rx_hit    = rx_valid && rx_en;
  assign pps_start = rx_hit && (state_q == PH_WAIT_CMD) && (rx_byte == PPS_INTRO);
  assign pps_take  = rx_hit && (state_q == PH_IN_PPS);
  assign hdr_take  = rx_hit && (((state_q == PH_WAIT_CMD) && (rx_byte != PPS_INTRO))
                                || (state_q == PH_IN_CMD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcc_q <= 1'b0;
      rst_q <= 1'b1;
    end else begin
      vcc_q <= vcc_on;
      rst_q <= rst_act;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_WAIT_CLK: if (clk_on) state_d = PH_WAIT_RST;
      PH_SEND_ATR: if (tx_fire && atr_last) state_d = PH_WAIT_CMD;
      PH_WAIT_CMD: begin
        if (pps_start)     state_d = PH_IN_PPS;
        else if (hdr_take) state_d = PH_IN_CMD;
      end
      PH_IN_PPS:   if (pps_done) state_d = PH_WAIT_CMD;
      default: ;
    endcase
    if (pwr_rise)  state_d = PH_WAIT_CLK;
    if (start_atr) state_d = PH_SEND_ATR;
    if (!vcc_on)   state_d = PH_WAIT_PWR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PH_WAIT_PWR;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_count  <= '0;
      tx_count  <= '0;
      pps_count <= '0;
    end else begin
      if (rx_valid)  rx_count  <= rx_count + 1'b1;
      if (tx_fire)   tx_count  <= tx_count + 1'b1;
      if (pps_start) pps_count <= pps_count + 1'b1;
    end
  end

  assign rx_en    = (state_q == PH_WAIT_CMD) || (state_q == PH_IN_PPS)
                 || ((state_q == PH_IN_CMD) && !hdr_full);
  assign tx_en    = (state_q == PH_SEND_ATR) || ((state_q == PH_IN_CMD) && hdr_full);
  assign tx_valid = (state_q == PH_SEND_ATR);
  assign phase    = state_q;

  cs_atr_store #(.ATR_MAX(ATR_MAX), .IDX_W(IDX_W)) u_atr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (atr_wr_en),
    .wr_idx     (atr_wr_idx),
    .wr_byte    (atr_wr_byte),
    .commit     (atr_commit),
    .commit_len (atr_commit_len),
    .busy       (state_q == PH_SEND_ATR),
    .rewind     (start_atr),
    .advance    (tx_fire && !start_atr),
    .cur_byte   (tx_byte),
    .last       (atr_last)
  );

  cs_pps_track u_pps (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pps_start),
    .take    (pps_take),
    .fmt_opt (rx_byte[6:4]),
    .done    (pps_done)
  );

  cs_hdr_capture #(.HDR_BYTES(HDR_N)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_q != PH_IN_CMD),
    .take      (hdr_take),
    .byte_in   (rx_byte),
    .hdr_word  (hdr_bytes),
    .hdr_pulse (hdr_valid),
    .hdr_full  (hdr_full)
  );

  // R2: loss of supply always lands in wait-power
  p_pwr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_on |=> phase == PH_WAIT_PWR);

  // R3: a supply rise leads to wait-clock
  p_pwr_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rise && !start_atr) |=> phase == PH_WAIT_CLK);

  // R4: a qualified reset release starts the ATR
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_atr |=> (phase == PH_SEND_ATR) && tx_valid && tx_en);

  // R7: the last accepted ATR byte opens the receiver
  p_atr_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && atr_last && vcc_on && !start_atr) |=> (phase == PH_WAIT_CMD) && rx_en && !tx_en);

  // R12: bytes in the early phases do not move the session
  p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (state_q inside {PH_WAIT_PWR, PH_WAIT_RST}) && vcc_on && !pwr_rise && !start_atr)
      |=> $stable(phase));

  // R11: a complete header always comes with the line turned around
  p_turn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && phase == PH_IN_CMD) |-> (!rx_en && tx_en));

  // R13: every received byte is counted
  p_rx_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_count == CNT_W'($past(rx_count) + 1'b1));

endmodule

// File: tb/card_session_ctrl_test.sv
module card_session_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vcc_on, clk_on, rst_act;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_en, tx_ready, tx_valid, tx_en;
  logic [7:0]  tx_byte;
  logic        atr_wr_en, atr_commit;
  logic [5:0]  atr_wr_idx, atr_commit_len;
  logic [7:0]  atr_wr_byte;
  logic        hdr_valid;
  logic [39:0] hdr_bytes;
  logic [2:0]  phase;
  logic [31:0] rx_count, tx_count, pps_count;

  int checks = 0;
  int fails  = 0;
  int rx_sent = 0;
  int tx_seen = 0;
  bit done = 0;

  logic [7:0]  exp_tx[$];
  logic [39:0] exp_hdr[$];
  logic [7:0]  e_tx;
  logic [39:0] e_hdr;

  always #4 clk = ~clk;

  card_session_ctrl uut (
    .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .clk_on(clk_on), .rst_act(rst_act),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_en(rx_en),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_en(tx_en),
    .atr_wr_en(atr_wr_en), .atr_wr_idx(atr_wr_idx), .atr_wr_byte(atr_wr_byte),
    .atr_commit(atr_commit), .atr_commit_len(atr_commit_len),
    .hdr_valid(hdr_valid), .hdr_bytes(hdr_bytes), .phase(phase),
    .rx_count(rx_count), .tx_count(tx_count), .pps_count(pps_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    rx_sent++;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] b);
    atr_wr_en = 1'b1; atr_wr_idx = 6'(idx); atr_wr_byte = b;
    step();
    atr_wr_en = 1'b0;
  endtask

  task automatic commit(input int len);
    atr_commit = 1'b1; atr_commit_len = 6'(len);
    step();
    atr_commit = 1'b0;
  endtask

  task automatic wait_phase(input logic [2:0] t, input int maxc, input string tag);
    for (int k = 0; k < maxc && phase != t; k++) step();
    chk(phase == t, tag, phase, t);
  endtask

  task automatic reset_pulse();
    rst_act = 1'b1; step();
    rst_act = 1'b0; step();
  endtask

  // scoreboard monitor, sampled half a cycle away from the active edge
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_seen++;
      if (exp_tx.size() == 0) chk(1'b0, "R5 unexpected ATR byte", tx_byte, 0);
      else begin
        e_tx = exp_tx.pop_front();
        chk(tx_byte == e_tx, "R5/R6/R8 ATR byte", tx_byte, e_tx);
      end
    end
    if (hdr_valid) begin
      if (exp_hdr.size() == 0) chk(1'b0, "R11 unexpected header", hdr_bytes, 0);
      else begin
        e_hdr = exp_hdr.pop_front();
        chk(hdr_bytes == e_hdr, "R11 header bytes", hdr_bytes, e_hdr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vcc_on = 1'b0; clk_on = 1'b0; rst_act = 1'b1;
    rx_valid = 1'b0; rx_byte = '0; tx_ready = 1'b0;
    atr_wr_en = 1'b0; atr_wr_idx = '0; atr_wr_byte = '0;
    atr_commit = 1'b0; atr_commit_len = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(phase == 3'd0 && !rx_en && !tx_en && !tx_valid && !hdr_valid, "R1 reset outputs",
        {phase, rx_en, tx_en, tx_valid}, 0);
    chk(rx_count == 0 && tx_count == 0 && pps_count == 0, "R1 counters", rx_count, 0);

    // R12 byte ignored without power
    send(8'hA0);
    chk(phase == 3'd0, "R12 byte in wait-power", phase, 0);

    // R3 power then clock
    vcc_on = 1'b1; step();
    chk(phase == 3'd1, "R3 power rise", phase, 1);
    send(8'h11);
    chk(phase == 3'd1, "R12 byte in wait-clock", phase, 1);
    clk_on = 1'b1; step();
    chk(phase == 3'd2, "R3 clock active", phase, 2);
    send(8'h22);
    chk(phase == 3'd2, "R12 byte in wait-reset", phase, 2);

    // R4/R5/R6 default ATR with a stalled transmitter
    exp_tx.push_back(8'h3B); exp_tx.push_back(8'h02);
    exp_tx.push_back(8'h14); exp_tx.push_back(8'h50);
    rst_act = 1'b0; step();
    chk(phase == 3'd3 && tx_en && tx_valid, "R4 release starts ATR", phase, 3);
    step(); step();
    chk(tx_byte == 8'h3B, "R5 hold while not ready", tx_byte, 8'h3B);
    send(8'h33);
    chk(phase == 3'd3, "R12 byte while sending ATR", phase, 3);
    wr(0, 8'h99);
    commit(2);   // R8 rejected: ATR in progress
    tx_ready = 1'b1;
    wait_phase(3'd5, 20, "R7 ATR end phase");
    chk(rx_en && !tx_en, "R7 receiver on after ATR", {rx_en, tx_en}, 2'b10);
    chk(tx_count == 4, "R13 tx count", tx_count, 4);
    chk(exp_tx.size() == 0, "R6 all default bytes sent", exp_tx.size(), 0);

    // R9 PPS with one optional byte
    send(8'hFF);
    chk(phase == 3'd4, "R9 0xFF diverts", phase, 4);
    send(8'h10); send(8'h11);
    chk(phase == 3'd4, "R9 before check byte", phase, 4);
    send(8'h01);
    chk(phase == 3'd5, "R9 check byte returns", phase, 5);
    // R9 PPS with all three optional bytes
    send(8'hFF); send(8'h70); send(8'h01); send(8'h02); send(8'h03);
    chk(phase == 3'd4, "R9 three optional bytes", phase, 4);
    send(8'h8C);
    chk(phase == 3'd5, "R9 end of long request", phase, 5);
    // R9 PPS without optional bytes
    send(8'hFF); send(8'h00);
    chk(phase == 3'd4, "R9 short request", phase, 4);
    send(8'hFF);
    chk(phase == 3'd5, "R9 short check byte", phase, 5);
    chk(pps_count == 3, "R13 pps count", pps_count, 3);

    // R10/R11 command header
    exp_hdr.push_back(40'h02_00_00_A4_A0);
    send(8'hA0);
    chk(phase == 3'd6 && rx_en, "R10 first header byte", phase, 6);
    send(8'hA4); send(8'h00); send(8'h00);
    chk(!hdr_valid && rx_en, "R10 header incomplete", hdr_valid, 0);
    send(8'h02);
    chk(hdr_valid && !rx_en && tx_en, "R11 turnaround", {hdr_valid, rx_en, tx_en}, 3'b101);
    step();
    chk(!hdr_valid, "R11 single-cycle strobe", hdr_valid, 0);
    send(8'h77);
    chk(phase == 3'd6 && !hdr_valid && tx_en, "R11 extra byte ignored", phase, 6);

    // R8 accepted load, then rejected ones
    wr(0, 8'h3B); wr(1, 8'h11); wr(2, 8'h22);
    commit(3);
    wr(0, 8'hEE);
    commit(34);
    commit(0);
    wr(40, 8'h55);
    exp_tx.push_back(8'h3B); exp_tx.push_back(8'h11); exp_tx.push_back(8'h22);
    reset_pulse();
    chk(phase == 3'd3, "R4 release from command phase", phase, 3);
    wait_phase(3'd5, 20, "R8 loaded ATR end");
    chk(exp_tx.size() == 0, "R8 loaded ATR length", exp_tx.size(), 0);

    // R2 power drop in mid-ATR
    tx_ready = 1'b0;
    reset_pulse();
    chk(phase == 3'd3, "R4 second release", phase, 3);
    vcc_on = 1'b0; step();
    chk(phase == 3'd0 && !tx_valid && !tx_en, "R2 power drop", phase, 0);
    vcc_on = 1'b1; step();
    chk(phase == 3'd1, "R3 power back", phase, 1);
    step();
    chk(phase == 3'd2, "R3 clock already running", phase, 2);
    clk_on = 1'b0;
    reset_pulse();
    chk(phase == 3'd2, "R4 release without clock", phase, 2);

    // R8 full-size ATR
    for (int i = 0; i < 33; i++) begin
      wr(i, 8'((i * 7 + 1) & 8'hFF));
      exp_tx.push_back(8'((i * 7 + 1) & 8'hFF));
    end
    commit(33);
    clk_on = 1'b1; tx_ready = 1'b1;
    reset_pulse();
    wait_phase(3'd5, 100, "R8 33-byte ATR end");
    chk(exp_tx.size() == 0, "R8 33-byte ATR length", exp_tx.size(), 0);

    // R10 second header pattern
    exp_hdr.push_back(40'h10_34_12_B0_00);
    send(8'h00); send(8'hB0); send(8'h12); send(8'h34); send(8'h10);
    chk(hdr_valid && phase == 3'd6, "R11 second header", phase, 6);
    step(); step();

    chk(exp_hdr.size() == 0, "R11 all headers seen", exp_hdr.size(), 0);
    chk(tx_count == 32'(tx_seen) && tx_seen == 40, "R13 tx total", tx_count, 40);
    chk(rx_count == 32'(rx_sent), "R13 rx total", rx_count, rx_sent);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule